// File: doc/BRIEF.md
# Front-End Register Address Router

The router sits between a single-word register bus and the per-link access logic of a detector readout board. It takes one 32-bit word address, splits it into a link (hub) index, a front-end chip index on that hub and a chip-internal register address, and issues exactly one downstream request for that target. Reads return the word the downstream side hands back; writes return a zero word. Targets outside the installed population are refused at once with an error response, and nothing is sent downstream for them.

Most chip registers live in one contiguous internal space: per-channel settings from 0x00 upward and general settings at 0x81 to 0x91. A few special registers (run control, hardware identity, identity version, a scratch test register and the unique chip identifier) live elsewhere. They are reached through a two-bit selector in the address, which routes the access through a small fixed remap table instead of the plain low-byte pass-through.

Top module: `fe_reg_router`

## Requirements
- R1: The hub index is taken from address bits [19:16] and the chip index from bits [15:11]; the downstream request carries both unchanged.
- R2: When address bits [10:9] are 00, address bits [7:0] are forwarded unchanged as the internal register address, for channel (0x00 to 0x7F) and general (0x81 to 0x91) registers alike.
- R3: When bits [10:9] are nonzero, the internal address comes from the remap table: selector 1 with low byte 0x00 gives 0xF0 (run control); selector 2 with low byte 0x00 gives 0xF8 (hardware identity) and with 0x01 gives 0xF9 (identity version); selector 3 with low byte 0x00 gives 0xFC (test register) and with 0x01 gives 0xFD (chip identifier).
- R4: A nonzero selector paired with any low byte not listed in R3 yields an error response with rsp_err=1 and rsp_rdata=0, and no downstream request.
- R5: A chip index of 24 or more, or a hub index of 12 or more, yields an error response in the cycle after acceptance and no downstream request.
- R6: The write flag and write data are forwarded with the request; after dn_done a read returns dn_rdata with rsp_err=0, and a write returns zero with rsp_err=0.
- R7: Only one access is in flight: up_ready is low from the cycle after acceptance until the response has been taken, and a downstream request only starts right after an upstream acceptance.
- R8: dn_valid and its fields stay stable until dn_ready; rsp_valid and its fields stay stable until rsp_ready.
- R9: Address bit 8 and bits [31:20] have no effect on the routed request.
- R10: After reset up_ready=1, dn_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream access request |
| up_ready | output | 1 | Router can accept an access |
| up_addr | input | 32 | Upstream word address |
| up_we | input | 1 | 1 = write, 0 = read |
| up_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Upstream takes the response |
| rsp_rdata | output | 32 | Read data (zero on writes and errors) |
| rsp_err | output | 1 | Access refused |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_hub | output | 4 | Target hub index |
| dn_chip | output | 5 | Target chip index |
| dn_addr | output | 8 | Chip-internal register address |
| dn_we | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data |
| dn_done | input | 1 | Downstream access finished |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The bench drives the upper corners of the index space (hub 11, chip 23 accepted; chip 24, hub 12 and hub 15 refused), where an off-by-one limit would either leak a request to a nonexistent chip or refuse a real one. Every remap entry is exercised along with unlisted selector/low-byte pairs, so a table that matched on the selector alone would route garbage instead of erroring. Addresses carry ones in bit 8 and the top bits to catch a decoder that slices the wrong fields, and both handshakes are stalled for a cycle to catch outputs that change or drop before being taken.

// File: rtl/fe_router_pkg.sv
package fe_router_pkg;

  localparam int unsigned REMAP_N = 5;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] low;
    logic [7:0] target;
  } remap_ent_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RESP
  } rtr_state_t;

  // Fixed special-register table: selector and low byte to internal address.
  function automatic remap_ent_t remap_entry(input int unsigned idx);
    remap_ent_t e;
    case (idx)
      0:       e = '{sel: 2'd1, low: 8'h00, target: 8'hF0}; // run control
      1:       e = '{sel: 2'd2, low: 8'h00, target: 8'hF8}; // hardware identity
      2:       e = '{sel: 2'd2, low: 8'h01, target: 8'hF9}; // identity version
      3:       e = '{sel: 2'd3, low: 8'h00, target: 8'hFC}; // test register
      default: e = '{sel: 2'd3, low: 8'h01, target: 8'hFD}; // chip identifier
    endcase
    return e;
  endfunction

endpackage

// File: rtl/fe_remap_table.sv
module fe_remap_table
  import fe_router_pkg::*;
#(
  parameter int unsigned IADDR_W = 8
) (
  input  logic [1:0]         sel,
  input  logic [IADDR_W-1:0] low,
  output logic               hit,
  output logic [IADDR_W-1:0] target
);

  logic [REMAP_N-1:0] match;
  logic [IADDR_W-1:0] tgt [REMAP_N];

  for (genvar i = 0; i < REMAP_N; i++) begin : g_ent
    localparam remap_ent_t ENT = remap_entry(i);
    assign match[i] = (sel == ENT.sel) && (low == IADDR_W'(ENT.low));
    assign tgt[i]   = IADDR_W'(ENT.target);
  end

  always_comb begin
    target = '0;
    for (int i = 0; i < REMAP_N; i++) begin
      if (match[i]) target = target | tgt[i];
    end
  end

  assign hit = |match;

endmodule

// File: rtl/fe_addr_decode.sv
module fe_addr_decode #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IADDR_W = 8,
  parameter int unsigned CHIP_W  = 5,
  parameter int unsigned HUB_W   = 4,
  parameter int unsigned N_HUBS  = 12,
  parameter int unsigned N_CHIPS = 24
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [HUB_W-1:0]   hub,
  output logic [CHIP_W-1:0]  chip,
  output logic [IADDR_W-1:0] iaddr,
  output logic               err
);

  localparam int unsigned SEL_LSB  = IADDR_W + 1;
  localparam int unsigned CHIP_LSB = SEL_LSB + 2;
  localparam int unsigned HUB_LSB  = CHIP_LSB + CHIP_W;
  localparam logic [HUB_W-1:0]  HUB_LIM  = HUB_W'(N_HUBS);
  localparam logic [CHIP_W-1:0] CHIP_LIM = CHIP_W'(N_CHIPS);

  logic [1:0]         sel;
  logic [IADDR_W-1:0] low;
  logic               remap_hit;
  logic [IADDR_W-1:0] remap_tgt;

  assign sel  = addr[SEL_LSB +: 2];
  assign low  = addr[IADDR_W-1:0];
  assign chip = addr[CHIP_LSB +: CHIP_W];
  assign hub  = addr[HUB_LSB +: HUB_W];

  fe_remap_table #(.IADDR_W(IADDR_W)) u_remap (
    .sel    (sel),
    .low    (low),
    .hit    (remap_hit),
    .target (remap_tgt)
  );

  assign iaddr = (sel == 2'd0) ? low : remap_tgt;
  assign err   = (hub >= HUB_LIM) || (chip >= CHIP_LIM) ||
                 ((sel != 2'd0) && !remap_hit);

endmodule

// File: rtl/fe_reg_router.sv
module fe_reg_router
  import fe_router_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IADDR_W = 8,
  parameter int unsigned CHIP_W  = 5,
  parameter int unsigned HUB_W   = 4,
  parameter int unsigned N_HUBS  = 12,
  parameter int unsigned N_CHIPS = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [ADDR_W-1:0]  up_addr,
  input  logic               up_we,
  input  logic [DATA_W-1:0]  up_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [HUB_W-1:0]   dn_hub,
  output logic [CHIP_W-1:0]  dn_chip,
  output logic [IADDR_W-1:0] dn_addr,
  output logic               dn_we,
  output logic [DATA_W-1:0]  dn_wdata,
  input  logic               dn_done,
  input  logic [DATA_W-1:0]  dn_rdata
);

  localparam logic [HUB_W-1:0]  HUB_LIM  = HUB_W'(N_HUBS);
  localparam logic [CHIP_W-1:0] CHIP_LIM = CHIP_W'(N_CHIPS);

  rtr_state_t         state;
  logic [HUB_W-1:0]   dec_hub;
  logic [CHIP_W-1:0]  dec_chip;
  logic [IADDR_W-1:0] dec_iaddr;
  logic               dec_err;

  fe_addr_decode #(
    .ADDR_W (ADDR_W), .IADDR_W(IADDR_W), .CHIP_W(CHIP_W),
    .HUB_W  (HUB_W),  .N_HUBS (N_HUBS),  .N_CHIPS(N_CHIPS)
  ) u_dec (
    .addr  (up_addr),
    .hub   (dec_hub),
    .chip  (dec_chip),
    .iaddr (dec_iaddr),
    .err   (dec_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dn_hub    <= '0;
      dn_chip   <= '0;
      dn_addr   <= '0;
      dn_we     <= 1'b0;
      dn_wdata  <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (up_valid) begin
          if (dec_err) begin
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            state     <= ST_RESP;
          end else begin
            dn_hub   <= dec_hub;
            dn_chip  <= dec_chip;
            dn_addr  <= dec_iaddr;
            dn_we    <= up_we;
            dn_wdata <= up_wdata;
            state    <= ST_REQ;
          end
        end
        ST_REQ:  if (dn_ready) state <= ST_WAIT;
        ST_WAIT: if (dn_done) begin
          rsp_err   <= 1'b0;
          rsp_rdata <= dn_we ? '0 : dn_rdata;
          state     <= ST_RESP;
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  assign up_ready  = (state == ST_IDLE);
  assign dn_valid  = (state == ST_REQ);
  assign rsp_valid = (state == ST_RESP);

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_hub) && $stable(dn_chip)); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R8
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) |-> $past(up_valid && up_ready)); // R7
  AST_TARGET_RANGE: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_hub < HUB_LIM) && (dn_chip < CHIP_LIM)); // R5
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_rdata == '0); // R4
  AST_FREE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready |=> up_ready && !rsp_valid); // R7

endmodule

// File: tb/fe_reg_router_tb.sv
module fe_reg_router_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic [31:0] up_addr = '0;
  logic        up_we = 1'b0;
  logic [31:0] up_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [3:0]  dn_hub;
  logic [4:0]  dn_chip;
  logic [7:0]  dn_addr;
  logic        dn_we;
  logic [31:0] dn_wdata;
  logic        dn_done = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fe_reg_router u_dut (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_we(up_we), .up_wdata(up_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_hub(dn_hub), .dn_chip(dn_chip),
    .dn_addr(dn_addr), .dn_we(dn_we), .dn_wdata(dn_wdata),
    .dn_done(dn_done), .dn_rdata(dn_rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int hub, input int chip, input int sel, input int low);
    return (32'(hub) << 16) | (32'(chip) << 11) | (32'(sel) << 9) | 32'(low & 8'hFF);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Accepted access: full downstream round trip with one stall on each side.
  task automatic t_good(input logic [31:0] addr, input bit we, input logic [31:0] wd,
                        input int hub, input int chip, input int iaddr,
                        input logic [31:0] ret, input string req);
    up_addr = addr; up_we = we; up_wdata = wd; up_valid = 1'b1;
    tick();
    up_valid = 1'b0;
    chk(dn_valid === 1'b1, req, 32'(dn_valid), 32'd1);
    chk(dn_hub == 4'(hub) && dn_chip == 5'(chip), {req, " R1 target"},
        {dn_hub, 11'd0, dn_chip}, 32'(hub) << 16 | 32'(chip));
    chk(dn_addr == 8'(iaddr), {req, " internal address"}, 32'(dn_addr), 32'(iaddr));
    chk(dn_we == we && dn_wdata == wd, "R6 write fields", dn_wdata, wd);
    chk(up_ready === 1'b0, "R7 busy after accept", 32'(up_ready), 32'd0);
    tick();
    chk(dn_valid === 1'b1 && dn_addr == 8'(iaddr), "R8 request held", 32'(dn_addr), 32'(iaddr));
    dn_ready = 1'b1;
    tick();
    dn_ready = 1'b0;
    chk(dn_valid === 1'b0 && rsp_valid === 1'b0, "R7 waiting for done", 32'(dn_valid), 32'd0);
    dn_done = 1'b1; dn_rdata = ret;
    tick();
    dn_done = 1'b0; dn_rdata = '0;
    chk(rsp_valid === 1'b1 && rsp_err === 1'b0, "R6 response", 32'(rsp_err), 32'd0);
    chk(rsp_rdata == (we ? 32'd0 : ret), "R6 response data", rsp_rdata, we ? 32'd0 : ret);
    tick();
    chk(rsp_valid === 1'b1 && rsp_rdata == (we ? 32'd0 : ret), "R8 response held", rsp_rdata, we ? 32'd0 : ret);
    rsp_ready = 1'b1;
    tick();
    rsp_ready = 1'b0;
    chk(up_ready === 1'b1 && rsp_valid === 1'b0, "R7 free again", 32'(up_ready), 32'd1);
  endtask

  // Refused access: error in the cycle after acceptance, no downstream request.
  task automatic t_err(input logic [31:0] addr, input string req);
    up_addr = addr; up_we = 1'b0; up_valid = 1'b1;
    tick();
    up_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_err === 1'b1, req, 32'(rsp_err), 32'd1);
    chk(rsp_rdata == 32'd0, {req, " data zero"}, rsp_rdata, 32'd0);
    chk(dn_valid === 1'b0, {req, " no request"}, 32'(dn_valid), 32'd0);
    rsp_ready = 1'b1;
    tick();
    rsp_ready = 1'b0;
    chk(dn_valid === 1'b0 && up_ready === 1'b1, {req, " idle after"}, 32'(dn_valid), 32'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    chk(up_ready === 1'b1 && dn_valid === 1'b0 && rsp_valid === 1'b0, "R10 reset state",
        {29'd0, up_ready, dn_valid, rsp_valid}, 32'd4);

    // R9: bit 8 and top bits set, must not disturb the route
    t_good(32'hABC0_0000 | mk_addr(3, 7, 0, 8'h05) | 32'h100, 1'b0, 32'd0, 3, 7, 8'h05,
           32'h1234_5678, "R2 R9 channel read");
    t_good(mk_addr(0, 0, 0, 8'h00), 1'b0, 32'd0, 0, 0, 8'h00, 32'hCAFE_0001, "R2 first channel");
    t_good(mk_addr(11, 23, 0, 8'h91), 1'b1, 32'hDEAD_BEEF, 11, 23, 8'h91,
           32'h5555_5555, "R1 R6 top corner write");
    t_good(mk_addr(5, 2, 0, 8'h81), 1'b0, 32'd0, 5, 2, 8'h81, 32'h0000_0081, "R2 general reg");

    t_good(mk_addr(1, 1, 1, 8'h00), 1'b0, 32'd0, 1, 1, 8'hF0, 32'hA0, "R3 run control");
    t_good(mk_addr(2, 4, 2, 8'h00), 1'b0, 32'd0, 2, 4, 8'hF8, 32'hA1, "R3 hw identity");
    t_good(mk_addr(2, 4, 2, 8'h01), 1'b0, 32'd0, 2, 4, 8'hF9, 32'hA2, "R3 identity version");
    t_good(mk_addr(6, 9, 3, 8'h00), 1'b1, 32'h0BAD_F00D, 6, 9, 8'hFC, 32'hA3, "R3 test register");
    t_good(32'hFFF0_0100 | mk_addr(6, 9, 3, 8'h01), 1'b0, 32'd0, 6, 9, 8'hFD, 32'hA4, "R3 R9 chip id");

    t_err(mk_addr(1, 1, 1, 8'h01), "R4 unlisted remap sel1");
    t_err(mk_addr(1, 1, 2, 8'h05), "R4 unlisted remap sel2");
    t_err(mk_addr(0, 24, 0, 8'h10), "R5 chip 24");
    t_err(mk_addr(12, 0, 0, 8'h10), "R5 hub 12");
    t_err(mk_addr(15, 31, 0, 8'h10), "R5 hub 15 chip 31");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule